// File: doc/BRIEF.md
# PHY Interrupt Mask and Status Unit

This unit collects single-cycle event pulses from a copper Ethernet PHY core and records each one in a sticky bit of a 16-bit status register. The events are link state change, link speed change, duplex change, auto-downspeed detect, auto-negotiation complete, auto-negotiation error and wake-on-LAN. The logic that produces these events is outside this block; here they are plain input pulses.

A 16-bit mask register selects which status bits may raise the interrupt. The level-sensitive, active-high interrupt output is the OR of every status bit whose mask bit is set. Both registers sit on a small management register bus. A read of the status register hands its contents to software and clears every pending bit in the same operation. Software normally writes 0 to the mask to silence everything. In service it typically enables only link state change and auto-downspeed detect, which is mask value 0x0021.

Top module: `phyirq_unit`

## Requirements
- R1: While reset is held (rst_ni low), and at the first cycle after it is released, the status and mask registers are zero, irq_o is low and rd_data_o is zero.
- R2: Event input evt_i[k] for k = 0..6 sets status bit 0, 1, 2, 5, 10, 11 and 15 respectively (link state, link speed, duplex, auto-downspeed, auto-negotiation complete, auto-negotiation error, wake-on-LAN). The bit is set on the clock edge that samples the pulse. It stays set whatever the mask holds, until a status read clears it.
- R3: A read (rd_en_i high) at address 0x1A puts the status value held before that edge on rd_data_o in the next cycle and clears every status bit. A bit whose event pulse arrives in the same cycle as the read remains set.
- R4: A write (wr_en_i high) at address 0x19 loads all 16 bits of wr_data_i into the mask. A read at 0x19 returns the mask on rd_data_o in the next cycle and changes no state.
- R5: irq_o is high exactly when some bit is set in both the status and the mask register. It follows the registers in the same cycle.
- R6: With a mask of 0x0000, irq_o stays low whatever status bits are pending.
- R7: Status bits 3, 4, 6, 7, 8, 9, 12, 13 and 14 always read as 0.
- R8: A write to 0x1A or to any address other than 0x19 changes neither register. A read at any address other than 0x19 or 0x1A returns 0.
- R9: In a cycle that does not follow a read, rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| evt_i | input | 7 | Event pulses, one per event type |
| addr_i | input | 5 | Management register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt, active high level |

## Verification
Checks run on every cycle for these properties: events are captured in their bits, bits hold when there is neither an event nor a clear, a status read empties the register, mask writes load the mask, unused positions stay zero, a zero mask keeps the interrupt low, and the read port shows the status value or zero. Some behaviour can only be shown by the bench's scenarios. These are the exact mapping from each event input to its bit position, an event winning over a clear in the same cycle, the 0x0021 mask gating the interrupt, and writes to the status address or to stray addresses being ignored. The bench shows each of them with directed sequences and a seeded random mix of events, reads and writes, all compared against a reference model.

// File: rtl/phyirq_pkg.sv
package phyirq_pkg;
    localparam int DATA_W = 16;
    localparam int N_EV   = 7;

    typedef struct packed {
        logic [DATA_W-1:0] stat;
    } stat_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mask_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    // bit position taken by each event input; software decodes these
    function automatic int ev_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 5;
            4:       return 10;
            5:       return 11;
            default: return 15;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] impl_bits();
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < N_EV; i++) v[ev_pos(i)] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/phyirq_evmap.sv
module phyirq_evmap
    import phyirq_pkg::*;
(
    input  logic [N_EV-1:0]   evt_i,
    output logic [DATA_W-1:0] set_o
);
    always_comb begin
        set_o = '0;
        for (int i = 0; i < N_EV; i++) set_o[ev_pos(i)] = evt_i[i];
    end
endmodule

// File: rtl/phyirq_status.sv
module phyirq_status
    import phyirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] set_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] stat_o
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.stat = '0;
        st_d.stat = st_d.stat | set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    // R2
    ev_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((st_q.stat & $past(set_i)) == $past(set_i)));
    // R2
    ev_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && set_i == '0) |=> $stable(st_q.stat));
    // R3
    rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && set_i == '0) |=> (st_q.stat == '0));
endmodule

// File: rtl/phyirq_mask.sv
module phyirq_mask
    import phyirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    mask_state_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (we_i) mk_d.mask = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) mk_q <= '0;
        else         mk_q <= mk_d;
    end

    assign mask_o = mk_q.mask;

    // R4
    mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (mk_q.mask == $past(wdata_i)));
    // R8
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(mk_q.mask));
endmodule

// File: rtl/phyirq_rdport.sv
module phyirq_rdport
    import phyirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic              sel_mask_i,
    input  logic              sel_stat_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] stat_i,
    output logic [DATA_W-1:0] rdata_o
);
    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d.rdata = '0;
        if (rd_en_i) begin
            if (sel_mask_i)      rd_d.rdata = mask_i;
            else if (sel_stat_i) rd_d.rdata = stat_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rdata;
endmodule

// File: rtl/phyirq_unit.sv
module phyirq_unit
    import phyirq_pkg::*;
#(
    parameter int          ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 5'h19,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h1A
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_EV-1:0]   evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] IMPL = impl_bits();

    logic [DATA_W-1:0] set_vec, stat_q, mask_q;
    logic hit_mask, hit_stat;

    assign hit_mask = (addr_i == MASK_ADDR);
    assign hit_stat = (addr_i == STAT_ADDR);

    phyirq_evmap u_evmap (
        .evt_i (evt_i),
        .set_o (set_vec)
    );

    phyirq_status u_status (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec),
        .clr_i  (rd_en_i && hit_stat),
        .stat_o (stat_q)
    );

    phyirq_mask u_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_en_i && hit_mask),
        .wdata_i (wr_data_i),
        .mask_o  (mask_q)
    );

    phyirq_rdport u_rdport (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_en_i    (rd_en_i),
        .sel_mask_i (hit_mask),
        .sel_stat_i (hit_stat),
        .mask_i     (mask_q),
        .stat_i     (stat_q),
        .rdata_o    (rd_data_o)
    );

    assign irq_o = |(stat_q & mask_q);

    // R7
    unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_q & ~IMPL) == '0));
    // R6
    zero_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '0) |-> !irq_o);
    // R3
    stat_read_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && hit_stat) |=> (rd_data_o == $past(stat_q)));
    // R9
    idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rd_data_o == '0));
endmodule

// File: tb/phyirq_unit_tb.sv
module phyirq_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic [6:0]  evt_i;
    logic [4:0]  addr_i;
    logic        wr_en_i;
    logic [15:0] wr_data_i;
    logic        rd_en_i;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_stat, m_mask, m_rd;
    string rd_tag;

    localparam logic [4:0] A_MASK = 5'h19;
    localparam logic [4:0] A_STAT = 5'h1A;

    always #5 clk_i = ~clk_i;

    phyirq_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [15:0] ev_bits(input logic [6:0] e);
        logic [15:0] v;
        v = 16'h0;
        v[0] = e[0]; v[1] = e[1]; v[2] = e[2]; v[5] = e[3];
        v[10] = e[4]; v[11] = e[5]; v[15] = e[6];
        return v;
    endfunction

    function automatic logic exp_irq(input logic [15:0] s, input logic [15:0] m);
        return |(s & m);
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] e, input logic rd, input logic wr,
                        input logic [4:0] a, input logic [15:0] wd);
        evt_i = e; rd_en_i = rd; wr_en_i = wr; addr_i = a; wr_data_i = wd;
        @(posedge clk_i);
        if (!rd)              begin m_rd = 16'h0;  rd_tag = "R9"; end
        else if (a == A_MASK) begin m_rd = m_mask; rd_tag = "R4"; end
        else if (a == A_STAT) begin m_rd = m_stat; rd_tag = "R3"; end
        else                  begin m_rd = 16'h0;  rd_tag = "R8"; end
        m_stat = ((rd && a == A_STAT) ? 16'h0 : m_stat) | ev_bits(e);
        if (wr && a == A_MASK) m_mask = wd;
        @(negedge clk_i);
        evt_i = '0; rd_en_i = 0; wr_en_i = 0;
        check16(rd_tag, rd_data_o, m_rd);
        if (rd && a == A_STAT) check16("R7", rd_data_o & 16'h73D8, 16'h0);
        check16(m_mask == 0 ? "R6" : "R5", {15'h0, irq_o}, {15'h0, exp_irq(m_stat, m_mask)});
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] seed_dummy;
        seed_dummy = 16'($urandom(32'h1234_5678));
        rst_ni = 0; evt_i = '0; addr_i = '0; wr_en_i = 0; wr_data_i = '0; rd_en_i = 0;
        m_stat = 0; m_mask = 0; m_rd = 0;
        repeat (3) @(negedge clk_i);
        // R1 reset state
        check16("R1", rd_data_o, 16'h0);
        check16("R1", {15'h0, irq_o}, 16'h0);
        rst_ni = 1;
        @(negedge clk_i);
        check16("R1", rd_data_o, 16'h0);
        check16("R1", {15'h0, irq_o}, 16'h0);
        step(7'h0, 1, 0, A_STAT, 0);
        check16("R1", rd_data_o, 16'h0);
        step(7'h0, 1, 0, A_MASK, 0);
        check16("R1", rd_data_o, 16'h0);

        // R2 each event to its own bit, latched with mask at zero
        for (int k = 0; k < 7; k++) begin
            step(7'(1 << k), 0, 0, 5'h0, 0);
            step(7'h0, 1, 0, A_STAT, 0);
            check16("R2", rd_data_o, ev_bits(7'(1 << k)));
        end

        // R5 typical mask 0x0021
        step(7'h0, 0, 1, A_MASK, 16'h0021);
        step(7'b0000010, 0, 0, 5'h0, 0);
        check16("R5", {15'h0, irq_o}, 16'h0);
        step(7'b0001000, 0, 0, 5'h0, 0);
        check16("R5", {15'h0, irq_o}, 16'h1);
        step(7'h0, 1, 0, A_STAT, 0);
        check16("R3", rd_data_o, 16'h0022);
        check16("R3", {15'h0, irq_o}, 16'h0);

        // R3 event arriving with a clearing read survives
        step(7'b0000001, 0, 0, 5'h0, 0);
        step(7'b1000000, 1, 0, A_STAT, 0);
        check16("R3", rd_data_o, 16'h0001);
        step(7'h0, 1, 0, A_STAT, 0);
        check16("R3", rd_data_o, 16'h8000);

        // R8 writes to status and stray addresses ignored, stray reads zero
        step(7'h0, 0, 1, A_STAT, 16'hFFFF);
        step(7'h0, 0, 1, 5'h03, 16'hFFFF);
        step(7'h0, 1, 0, A_STAT, 0);
        check16("R8", rd_data_o, 16'h0);
        step(7'h0, 1, 0, A_MASK, 0);
        check16("R8", rd_data_o, 16'h0021);
        step(7'h0, 1, 0, 5'h03, 0);
        check16("R8", rd_data_o, 16'h0);

        // R6 zero mask with everything pending
        step(7'h7F, 0, 1, A_MASK, 16'h0000);
        check16("R6", {15'h0, irq_o}, 16'h0);
        step(7'h0, 1, 0, A_STAT, 0);
        check16("R7", rd_data_o, 16'h8C27);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [6:0]  e;
            logic [4:0]  a;
            logic        rd, wr;
            int          pick;
            e  = ($urandom % 4 == 0) ? 7'(1 << ($urandom % 7)) : 7'h0;
            if ($urandom % 16 == 0) e = 7'($urandom);
            rd = ($urandom % 4 == 0);
            wr = ($urandom % 6 == 0);
            pick = $urandom % 5;
            a  = (pick < 2) ? A_MASK : (pick < 4) ? A_STAT : 5'($urandom);
            step(e, rd, wr, a, 16'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule